// File: doc/BRIEF.md
# Primary/Secondary Serial Frame Sequencer

This block runs one end of a synchronous serial link that moves 16-bit words, most significant bit first. It makes the shift clock from the system clock and drives an active-low transmit frame sync. In synchronous mode it also drives an active-low receive frame sync. Each conversion strobe opens one primary frame. During that frame the block collects a word from the serial data input, the word meant for the conversion timer, and shifts a converter sample out on the serial data output.

The two lowest bits of a finished primary word can ask for a secondary frame. When they do, transmit sync stays released for four shift-clock cycles and then opens a secondary frame of the same length and timing. That frame carries a configuration word, which goes to a separate output with its own one-cycle valid pulse. Receive sync stays released for the whole secondary frame.

Primary timing takes precedence. If a conversion strobe arrives while a secondary frame is still waiting to start, the secondary frame is dropped. An overrun pulse is raised and the primary frame starts on schedule.

Top module: `frame_seq`

## Requirements
- R1: While reset is high, and on the clock after it, fsx_n and fsr_n are 1 and sclk, dr, prim_valid, cfg_valid and overrun are 0. A reset in the middle of a frame releases both syncs.
- R2: sclk is a square wave with a period of 2*HALF_DIV system clocks. fsx_n, fsr_n and dr change only on the system clock edge where sclk rises.
- R3: After a conv_start pulse, fsx_n falls at the first following rising edge of sclk and stays low for 16 sclk periods. dx is sampled on the 16 falling edges in between, first bit into bit 15. The word appears on prim_word with a one-clock prim_valid pulse on the edge where fsx_n returns high.
- R4: During a primary frame, dr carries adc_word MSB first. Bit 15 is placed at the rise where fsx_n falls, and each later rise brings the next lower bit.
- R5: For a primary frame, fsr_n goes low together with fsx_n when sync_mode is 1 at the frame start. When sync_mode is 0 it stays 1.
- R6: A secondary frame follows only when bits 1 and 0 of the finished primary word are both 1. With any other value, fsx_n stays high until the next strobe.
- R7: When a secondary frame is requested, fsx_n falls again at the fourth sclk rise after the rise that ended the primary frame.
- R8: A secondary frame lasts 16 sclk periods, like a primary frame. Its word goes out on cfg_word with a one-clock cfg_valid pulse where fsx_n returns high. prim_valid does not pulse and prim_word keeps its value.
- R9: fsr_n stays 1 for the whole of a secondary frame in both modes.
- R10: A conv_start that arrives during the four-cycle gap cancels the pending secondary frame. The primary frame starts at the next sclk rise, overrun pulses for one clock on that edge, and cfg_valid does not pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_start | input | 1 | One-clock conversion strobe that requests a primary frame |
| sync_mode | input | 1 | 1: receive sync follows primary frames; 0: receive sync held inactive |
| adc_word | input | 16 | Sample shifted out on dr during a primary frame |
| dx | input | 1 | Serial data in, sampled on sclk falling edges |
| sclk | output | 1 | Shift clock |
| fsx_n | output | 1 | Transmit frame sync, active low |
| fsr_n | output | 1 | Receive frame sync, active low |
| dr | output | 1 | Serial data out, changes on sclk rising edges |
| prim_word | output | 16 | Last completed primary word |
| prim_valid | output | 1 | One-clock pulse when prim_word updates |
| cfg_word | output | 16 | Last completed secondary (configuration) word |
| cfg_valid | output | 1 | One-clock pulse when cfg_word updates |
| overrun | output | 1 | One-clock pulse when a pending secondary frame is dropped |

## Verification
Every timed result of this block lands on an sclk rising edge.
- **Frame start:** fsx_n falls at the first rise after the strobe.
- **Word delivery:** prim_valid or cfg_valid pulses on the same clock edge where fsx_n returns high.
- **Secondary start:** the secondary frame begins on the fourth rise after that.
- **Overrun:** the overrun pulse shares its edge with the early fall of fsx_n.

The bench samples all outputs on the falling system-clock edge just after each such edge and numbers the sclk rises it sees. It then compares rise numbers: strobe-to-start is one rise, frame length is 16 rises and the gap is 4 rises. Valid and overrun values are captured in the very sample where the sync edge first appears.

// File: rtl/fs_pkg.sv
package fs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRI  = 2'd1,
    ST_GAP  = 2'd2,
    ST_SEC  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/fs_sclk_gen.sv
module fs_sclk_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  output logic sclk,
  output logic rise_tk,
  output logic fall_tk
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick    = (cnt == CW'(HALF_DIV - 1));
  assign rise_tk = tick & ~sclk;
  assign fall_tk = tick & sclk;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (tick) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fs_shifter.sv
module fs_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rise_tk,
  input  logic         fall_tk,
  input  logic         load_pri,
  input  logic         load_sec,
  input  logic         shift_en,
  input  logic         dx,
  input  logic [W-1:0] par_in,
  output logic         dr,
  output logic [W-1:0] rx_word
);
  logic [W-1:0] tx_reg;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_reg <= '0;
      dr     <= 1'b0;
    end else if (load_pri) begin
      dr     <= par_in[W-1];
      tx_reg <= {par_in[W-2:0], 1'b0};
    end else if (load_sec) begin
      dr     <= 1'b0;
      tx_reg <= '0;
    end else if (rise_tk && shift_en) begin
      dr     <= tx_reg[W-1];
      tx_reg <= {tx_reg[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_word <= '0;
    end else if (fall_tk && shift_en) begin
      rx_word <= {rx_word[W-2:0], dx};
    end
  end
endmodule

// File: rtl/fs_ctrl.sv
module fs_ctrl
  import fs_pkg::*;
#(
  parameter int W       = 16,
  parameter int GAP_CYC = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rise_tk,
  input  logic         fall_tk,
  input  logic         conv_start,
  input  logic         sync_mode,
  input  logic [W-1:0] rx_word,
  output logic         load_pri,
  output logic         load_sec,
  output logic         in_frame,
  output logic         sec_active,
  output logic         fsx_n,
  output logic         fsr_n,
  output logic [W-1:0] prim_word,
  output logic         prim_valid,
  output logic [W-1:0] cfg_word,
  output logic         cfg_valid,
  output logic         overrun
);
  localparam int BCW = $clog2(W + 1);
  localparam int GCW = $clog2(GAP_CYC + 1);

  seq_state_t     state;
  logic [BCW-1:0] bit_cnt;
  logic [GCW-1:0] gap_cnt;
  logic           pend;
  logic           req;
  logic           frame_end;

  assign req        = pend | conv_start;
  assign in_frame   = (state == ST_PRI) || (state == ST_SEC);
  assign sec_active = (state == ST_SEC);
  assign load_pri   = rise_tk && req && ((state == ST_IDLE) || (state == ST_GAP));
  assign load_sec   = rise_tk && !req && (state == ST_GAP) && (gap_cnt == GCW'(GAP_CYC));
  assign frame_end  = rise_tk && in_frame && (bit_cnt == BCW'(W));

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
    end else if (load_pri) begin
      pend <= 1'b0;
    end else if (conv_start) begin
      pend <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      bit_cnt    <= '0;
      gap_cnt    <= '0;
      fsx_n      <= 1'b1;
      fsr_n      <= 1'b1;
      prim_word  <= '0;
      prim_valid <= 1'b0;
      cfg_word   <= '0;
      cfg_valid  <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      prim_valid <= 1'b0;
      cfg_valid  <= 1'b0;
      overrun    <= 1'b0;
      if (fall_tk && in_frame) begin
        bit_cnt <= bit_cnt + 1'b1;
      end
      case (state)
        ST_IDLE: begin
          if (load_pri) begin
            state   <= ST_PRI;
            fsx_n   <= 1'b0;
            fsr_n   <= ~sync_mode;
            bit_cnt <= '0;
          end
        end
        ST_PRI: begin
          if (frame_end) begin
            fsx_n      <= 1'b1;
            fsr_n      <= 1'b1;
            prim_word  <= rx_word;
            prim_valid <= 1'b1;
            if (rx_word[1:0] == 2'b11) begin
              state   <= ST_GAP;
              gap_cnt <= GCW'(1);
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_GAP: begin
          if (load_pri) begin
            state   <= ST_PRI;
            fsx_n   <= 1'b0;
            fsr_n   <= ~sync_mode;
            bit_cnt <= '0;
            overrun <= 1'b1;
          end else if (load_sec) begin
            state   <= ST_SEC;
            fsx_n   <= 1'b0;
            bit_cnt <= '0;
          end else if (rise_tk) begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        ST_SEC: begin
          if (frame_end) begin
            fsx_n     <= 1'b1;
            cfg_word  <= rx_word;
            cfg_valid <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/frame_seq.sv
module frame_seq #(
  parameter int W        = 16,
  parameter int HALF_DIV = 2,
  parameter int GAP_CYC  = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         conv_start,
  input  logic         sync_mode,
  input  logic [W-1:0] adc_word,
  input  logic         dx,
  output logic         sclk,
  output logic         fsx_n,
  output logic         fsr_n,
  output logic         dr,
  output logic [W-1:0] prim_word,
  output logic         prim_valid,
  output logic [W-1:0] cfg_word,
  output logic         cfg_valid,
  output logic         overrun
);
  logic         rise_tk;
  logic         fall_tk;
  logic         load_pri;
  logic         load_sec;
  logic         in_frame;
  logic         sec_active;
  logic [W-1:0] rx_word;

  fs_sclk_gen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk     (clk),
    .rst     (rst),
    .sclk    (sclk),
    .rise_tk (rise_tk),
    .fall_tk (fall_tk)
  );

  fs_shifter #(.W(W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .rise_tk  (rise_tk),
    .fall_tk  (fall_tk),
    .load_pri (load_pri),
    .load_sec (load_sec),
    .shift_en (in_frame),
    .dx       (dx),
    .par_in   (adc_word),
    .dr       (dr),
    .rx_word  (rx_word)
  );

  fs_ctrl #(.W(W), .GAP_CYC(GAP_CYC)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .rise_tk    (rise_tk),
    .fall_tk    (fall_tk),
    .conv_start (conv_start),
    .sync_mode  (sync_mode),
    .rx_word    (rx_word),
    .load_pri   (load_pri),
    .load_sec   (load_sec),
    .in_frame   (in_frame),
    .sec_active (sec_active),
    .fsx_n      (fsx_n),
    .fsr_n      (fsr_n),
    .prim_word  (prim_word),
    .prim_valid (prim_valid),
    .cfg_word   (cfg_word),
    .cfg_valid  (cfg_valid),
    .overrun    (overrun)
  );
endmodule

// File: rtl/fs_checker.sv
module fs_checker (
  input logic clk,
  input logic rst,
  input logic sclk,
  input logic fsx_n,
  input logic fsr_n,
  input logic dr,
  input logic prim_valid,
  input logic cfg_valid,
  input logic overrun,
  input logic sec_active
);
  logic rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
  end

  // R1: outputs idle one clock after reset
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (fsx_n && fsr_n && !sclk && !dr && !prim_valid && !cfg_valid && !overrun));

  // R2: sync and data edges sit on sclk rising edges
  p_fsx_on_rise_r2: assert property (@(posedge clk) disable iff (rst || rst_q)
    !$stable(fsx_n) |-> (sclk && !$past(sclk)));

  p_fsr_on_rise_r2: assert property (@(posedge clk) disable iff (rst || rst_q)
    !$stable(fsr_n) |-> (sclk && !$past(sclk)));

  p_dr_on_rise_r2: assert property (@(posedge clk) disable iff (rst || rst_q)
    !$stable(dr) |-> (sclk && !$past(sclk)));

  // R3: primary word valid coincides with transmit sync release
  p_prim_at_release_r3: assert property (@(posedge clk) disable iff (rst || rst_q)
    prim_valid |-> (fsx_n && !$past(fsx_n)));

  // R5: receive sync only inside a transmit frame
  p_fsr_inside_fsx_r5: assert property (@(posedge clk) disable iff (rst)
    !fsr_n |-> !fsx_n);

  // R8: configuration word valid at release, never with primary valid
  p_cfg_at_release_r8: assert property (@(posedge clk) disable iff (rst || rst_q)
    cfg_valid |-> (fsx_n && !$past(fsx_n) && !prim_valid));

  // R9: no receive sync during a secondary frame
  p_no_rx_sync_sec_r9: assert property (@(posedge clk) disable iff (rst)
    sec_active |-> fsr_n);

  // R10: overrun marks an early primary start
  p_drop_starts_pri_r10: assert property (@(posedge clk) disable iff (rst || rst_q)
    overrun |-> (!fsx_n && $past(fsx_n)));
endmodule

bind frame_seq fs_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .sclk       (sclk),
  .fsx_n      (fsx_n),
  .fsr_n      (fsr_n),
  .dr         (dr),
  .prim_valid (prim_valid),
  .cfg_valid  (cfg_valid),
  .overrun    (overrun),
  .sec_active (sec_active)
);

// File: tb/frame_seq_bench.sv
`timescale 1ns/1ps
module frame_seq_bench;
  localparam int W    = 16;
  localparam int HALF = 2;
  localparam int NV   = 6;
  localparam int WD_LIMIT = 100000;

  // {pri, adc, sec, sync}
  localparam logic [48:0] VECS [0:NV-1] = '{
    {16'hA5F0, 16'h1234, 16'h0000, 1'b1},
    {16'h3C01, 16'h8001, 16'h0000, 1'b1},
    {16'hFFFE, 16'hFFFF, 16'h0000, 1'b0},
    {16'h1233, 16'h4321, 16'h0A5B, 1'b1},
    {16'h8003, 16'h0000, 16'hFFFF, 1'b0},
    {16'h0000, 16'hAAAA, 16'h0000, 1'b1}
  };

  logic         clk = 1'b0;
  logic         rst;
  logic         conv_start;
  logic         sync_mode;
  logic [W-1:0] adc_word;
  logic         dx;
  logic         sclk, fsx_n, fsr_n, dr;
  logic [W-1:0] prim_word, cfg_word;
  logic         prim_valid, cfg_valid, overrun;

  frame_seq #(.W(W), .HALF_DIV(HALF), .GAP_CYC(4)) u_frame_seq (
    .clk(clk), .rst(rst), .conv_start(conv_start), .sync_mode(sync_mode),
    .adc_word(adc_word), .dx(dx), .sclk(sclk), .fsx_n(fsx_n), .fsr_n(fsr_n),
    .dr(dr), .prim_word(prim_word), .prim_valid(prim_valid),
    .cfg_word(cfg_word), .cfg_valid(cfg_valid), .overrun(overrun)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // monitor state, updated on falling clk edges
  logic [W-1:0] cur_word = '0;
  logic         sclk_q = 1'b0, fsx_q = 1'b1, fsr_q = 1'b1;
  int cyc = 0, rcnt = 0, last_rise = 0;
  bit have_last = 0;
  int start_cnt = 0, end_cnt = 0, rise_mark = 0, fall_mark = 0, idx = 0;
  logic [W-1:0] rx_cap = '0, last_prim = '0, last_cfg = '0;
  bit prim_at_rise, cfg_at_rise, ovr_at_fall, fsr_at_fall, fsr_lo_seen, fsr_hi_in;
  int prim_cnt = 0, cfg_cnt = 0, ovr_cnt = 0, bad_edge = 0, per_bad = 0;

  always @(negedge clk) begin
    bit srise, sfall;
    cyc++;
    if (rst) begin
      have_last = 0;
    end else begin
      srise = sclk && !sclk_q;
      sfall = !sclk && sclk_q;
      if ((fsx_n != fsx_q || fsr_n != fsr_q) && !srise) bad_edge++;
      if (srise) begin
        rcnt++;
        if (have_last && (cyc - last_rise) != 2 * HALF) per_bad++;
        last_rise = cyc;
        have_last = 1;
      end
      if (prim_valid) prim_cnt++;
      if (cfg_valid) cfg_cnt++;
      if (overrun) ovr_cnt++;
      if (fsx_q && !fsx_n) begin
        start_cnt++;
        fall_mark   = rcnt;
        ovr_at_fall = overrun;
        fsr_at_fall = fsr_n;
        fsr_lo_seen = 0;
        fsr_hi_in   = 0;
        rx_cap      = '0;
      end
      if (!fsx_q && fsx_n) begin
        end_cnt++;
        rise_mark    = rcnt;
        prim_at_rise = prim_valid;
        cfg_at_rise  = cfg_valid;
        last_prim    = prim_word;
        last_cfg     = cfg_word;
      end
      if (!fsx_n) begin
        if (!fsr_n) fsr_lo_seen = 1;
        else        fsr_hi_in   = 1;
        if (sfall) rx_cap = {rx_cap[W-2:0], dr};
        if (srise) begin
          if (fsx_q) idx = W - 1;
          else if (idx > 0) idx = idx - 1;
          dx = cur_word[idx];
        end
      end
    end
    sclk_q = sclk;
    fsx_q  = fsx_n;
    fsr_q  = fsr_n;
  end

  // watchdog
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > WD_LIMIT) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", wd, WD_LIMIT);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic strobe(output int s);
    tick();
    s = rcnt;
    conv_start = 1'b1;
    tick();
    conv_start = 1'b0;
  endtask

  task automatic wait_start(input int n);
    while (start_cnt < n) tick();
  endtask

  task automatic wait_end(input int n);
    while (end_cnt < n) tick();
  endtask

  initial begin
    int s, st, en, cc;
    rst = 1'b1; conv_start = 1'b0; sync_mode = 1'b1; adc_word = '0; dx = 1'b0;
    repeat (5) tick();
    // R1: reset values
    check(fsx_n && fsr_n && !sclk && !dr && !prim_valid && !cfg_valid && !overrun,
          "R1", "reset outputs", {fsx_n, fsr_n, sclk, dr}, 4'b1100);
    rst = 1'b0;
    repeat (10) tick();
    check(fsx_n && fsr_n && !overrun, "R1", "idle after reset", {fsx_n, fsr_n}, 2'b11);

    for (int i = 0; i < NV; i++) begin
      logic [15:0] pri, adc, sec;
      logic        syn;
      {pri, adc, sec, syn} = VECS[i];
      sync_mode = syn;
      adc_word  = adc;
      cur_word  = pri;
      st = start_cnt; en = end_cnt; cc = cfg_cnt;
      strobe(s);
      wait_start(st + 1);
      check(fall_mark == s + 1, "R3", "start at first rise", fall_mark, s + 1);
      wait_end(en + 1);
      check(rise_mark - fall_mark == W, "R3", "frame length", rise_mark - fall_mark, W);
      check(prim_at_rise && last_prim == pri, "R3", "prim_word", last_prim, pri);
      check(rx_cap == adc, "R4", "dr stream", rx_cap, adc);
      if (syn) check(fsr_lo_seen && !fsr_hi_in && !fsr_at_fall, "R5", "fsr follows fsx",
                     {fsr_lo_seen, fsr_hi_in}, 2'b10);
      else     check(!fsr_lo_seen, "R5", "fsr held high", fsr_lo_seen, 0);
      if (pri[1:0] == 2'b11) begin
        cur_word = sec;
        wait_start(st + 2);
        check(fall_mark - rise_mark == 4, "R7", "gap rises", fall_mark - rise_mark, 4);
        wait_end(en + 2);
        check(rise_mark - fall_mark == W, "R8", "sec length", rise_mark - fall_mark, W);
        check(cfg_at_rise && last_cfg == sec && !prim_at_rise && prim_word == pri,
              "R8", "cfg_word", last_cfg, sec);
        check(!fsr_lo_seen, "R9", "fsr in secondary", fsr_lo_seen, 0);
      end else begin
        repeat (8 * 2 * HALF) tick();
        check(start_cnt == st + 1 && cfg_cnt == cc && fsx_n, "R6", "no secondary",
              start_cnt, st + 1);
      end
    end
    check(ovr_cnt == 0, "R10", "no overrun in normal flow", ovr_cnt, 0);

    // R10: strobe inside the gap drops the secondary frame
    sync_mode = 1'b1;
    adc_word  = 16'h0F0F;
    cur_word  = 16'h5557;
    st = start_cnt; en = end_cnt; cc = cfg_cnt;
    strobe(s);
    wait_end(en + 1);
    while (rcnt < rise_mark + 2) tick();
    cur_word = 16'h2468;
    strobe(s);
    wait_start(st + 2);
    check(fall_mark == s + 1 && fall_mark - rise_mark < 4, "R10", "early primary start",
          fall_mark, s + 1);
    check(ovr_at_fall && ovr_cnt == 1, "R10", "overrun pulse", ovr_cnt, 1);
    check(!fsr_at_fall, "R10", "dropped-gap frame is primary", fsr_at_fall, 0);
    wait_end(en + 2);
    check(prim_at_rise && last_prim == 16'h2468 && cfg_cnt == cc, "R10", "secondary dropped",
          last_prim, 16'h2468);
    repeat (8 * 2 * HALF) tick();
    check(cfg_cnt == cc && ovr_cnt == 1, "R10", "no late secondary", cfg_cnt, cc);

    // R2: clock period and edge alignment over the whole run
    check(per_bad == 0, "R2", "sclk period", per_bad, 0);
    check(bad_edge == 0, "R2", "sync edges on sclk rise", bad_edge, 0);

    // R1: reset in the middle of a frame
    cur_word = 16'hFFFF;
    st = start_cnt;
    strobe(s);
    wait_start(st + 1);
    while (rcnt < fall_mark + 5) tick();
    rst = 1'b1;
    tick();
    check(fsx_n && fsr_n && !dr && !sclk, "R1", "mid-frame reset", {fsx_n, fsr_n, dr}, 3'b110);
    rst = 1'b0;
    repeat (4) tick();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule